// File: doc/BRIEF.md
# Banked GPIO Controller with Grouped Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. It holds a parameterised number of 32-pin banks (two by default) behind a single-cycle register bus made up of write enable, byte address, write data and combinational read data. Each bank stores a direction mask and an output data word. Software can change the output data word through the plain data register, or change bits atomically through a set port or a clear port. Each bank also returns the synchronised pin levels, keeps per-pin enables for rising-edge and falling-edge detection (each enable with its own set and clear port), and holds a write-one-to-clear interrupt status word.

Interrupt requests are grouped by 16 pins, so each bank drives two level interrupt outputs. A global group-enable register gates every output. It is shared by all banks and sits at a fixed offset. A driver configures direction and edge enables, enables the group interrupts it wants, and acknowledges events by writing ones to the status word.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (all pins are inputs and all output enables are 0). Output data, edge enables, status, the group-enable register and every interrupt output are 0.
- R2: A direction bit of 0 makes its pin an output: the pin's output enable goes high and the pin carries that bank's output data bit. The output enables change only when a direction register is written.
- R3: A write to the set-data port (bank offset 0x08) drives the masked output bits to 1. A write to the clear-data port (bank offset 0x0C) drives them to 0. Unmasked bits keep their value. Reading either port returns the output data word, and offset 0x04 reads and writes that word directly.
- R4: The input data register (bank offset 0x10) returns the pin levels through a two-flop synchronizer. A pin change shows in a read two clock edges later and not after one edge.
- R5: The rising-enable set port (offset 0x14) and clear port (offset 0x18) set and clear mask bits of the rising enable, and both read back as that enable. A 0-to-1 transition on an enabled pin sets its status bit.
- R6: The falling-enable set port (offset 0x1C) and clear port (offset 0x20) behave the same way for 1-to-0 transitions. A transition whose type is not enabled leaves the status bit unchanged.
- R7: A pin with both enables set flags an event on either edge. A pin with neither enable set never flags an event.
- R8: Writing the status word (offset 0x24) clears exactly the bits written as 1.
- R9: When a status clear and a new enabled edge on the same bit fall in the same cycle, the bit ends up set.
- R10: The group-enable register sits at byte 0x08. Interrupt output k, for pins 16k to 16k+15 (bank k/2, half k%2), is high exactly while enable bit k is 1 and any status bit of that group is 1.
- R11: Bank n occupies bytes 0x10+0x28*n to 0x10+0x28*n+0x27. A write to one bank leaves the other banks unchanged, and unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pin_i | input | NUM_BANKS*32 | Pin input levels, asynchronous |
| pin_o | output | NUM_BANKS*32 | Pin output levels |
| pin_oe_o | output | NUM_BANKS*32 | Pin output enables, 1 = drive |
| irq_o | output | NUM_BANKS*2 | Level interrupt per 16-pin group |

## Verification
Software acknowledging a status bit and the edge detector flagging a new event on that same bit can land in the same clock edge. The bench provokes this by toggling an enabled pin, waiting one clock, and then issuing the write-one-to-clear. The synchronizer delay makes the detected edge coincide exactly with the clear write. The bit must read back as set afterwards. A second clear with no edge must then remove it, which shows that the first clear was really applied at the same time.

// File: rtl/egpio_pkg.sv
package egpio_pkg;
  localparam int WORD_W      = 32;
  localparam int GRP_W       = 16;
  localparam int GLB_EN_OFF  = 8;
  localparam int BANK_BASE   = 16;
  localparam int BANK_STRIDE = 40;

  localparam logic [5:0] R_DIR   = 6'h00;
  localparam logic [5:0] R_DOUT  = 6'h04;
  localparam logic [5:0] R_SET   = 6'h08;
  localparam logic [5:0] R_CLR   = 6'h0C;
  localparam logic [5:0] R_DIN   = 6'h10;
  localparam logic [5:0] R_SRISE = 6'h14;
  localparam logic [5:0] R_CRISE = 6'h18;
  localparam logic [5:0] R_SFALL = 6'h1C;
  localparam logic [5:0] R_CFALL = 6'h20;
  localparam logic [5:0] R_STAT  = 6'h24;

  function automatic int bank_base(int b);
    return BANK_BASE + b * BANK_STRIDE;
  endfunction
endpackage

// File: rtl/egpio_in_sync.sv
module egpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/egpio_bank.sv
module egpio_bank
  import egpio_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [5:0]   off_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] dir_q, dout_q, ren_q, fen_q, stat_q;
  logic [W-1:0] din, din_prev, hit, ack;

  egpio_in_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (din),
    .prev_o (din_prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '1;
      dout_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else if (wr_i) begin
      case (off_i)
        R_DIR:   dir_q  <= wdata_i;
        R_DOUT:  dout_q <= wdata_i;
        R_SET:   dout_q <= dout_q | wdata_i;
        R_CLR:   dout_q <= dout_q & ~wdata_i;
        R_SRISE: ren_q  <= ren_q | wdata_i;
        R_CRISE: ren_q  <= ren_q & ~wdata_i;
        R_SFALL: fen_q  <= fen_q | wdata_i;
        R_CFALL: fen_q  <= fen_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  // enabled edges seen this cycle; they override a same-cycle acknowledge
  assign hit = (din & ~din_prev & ren_q) | (~din & din_prev & fen_q);
  assign ack = (wr_i && off_i == R_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~ack) | hit;
  end

  always_comb begin
    case (off_i)
      R_DIR:                rdata_o = dir_q;
      R_DOUT, R_SET, R_CLR: rdata_o = dout_q;
      R_DIN:                rdata_o = din;
      R_SRISE, R_CRISE:     rdata_o = ren_q;
      R_SFALL, R_CFALL:     rdata_o = fen_q;
      R_STAT:               rdata_o = stat_q;
      default:              rdata_o = '0;
    endcase
  end

  assign pin_o  = dout_q;
  assign oe_o   = ~dir_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/egpio_irq_gate.sv
module egpio_irq_gate #(
  parameter int W = 16
) (
  input  logic [W-1:0] stat_i,
  input  logic         en_i,
  output logic         irq_o
);
  assign irq_o = en_i & (|stat_i);
endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
  import egpio_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [WORD_W-1:0]           wdata_i,
  output logic [WORD_W-1:0]           rdata_o,
  input  logic [NUM_BANKS*WORD_W-1:0] pin_i,
  output logic [NUM_BANKS*WORD_W-1:0] pin_o,
  output logic [NUM_BANKS*WORD_W-1:0] pin_oe_o,
  output logic [NUM_BANKS*2-1:0]      irq_o
);
  localparam int NPIN = NUM_BANKS * WORD_W;
  localparam int NGRP = NPIN / GRP_W;

  logic [NGRP-1:0]                glb_en_q;
  logic [NUM_BANKS-1:0]           bank_sel;
  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_rd;
  logic [NPIN-1:0]                stat_all;
  logic                           glb_hit;

  assign glb_hit = (int'(addr_i) == GLB_EN_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             glb_en_q <= '0;
    else if (we_i && glb_hit) glb_en_q <= wdata_i[NGRP-1:0];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BASE = bank_base(b);
    logic [5:0] off;
    assign bank_sel[b] = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + BANK_STRIDE);
    assign off = 6'(int'(addr_i) - BASE);

    egpio_bank #(.W(WORD_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && bank_sel[b]),
      .off_i   (off),
      .wdata_i (wdata_i),
      .rdata_o (bank_rd[b]),
      .pin_i   (pin_i[b*WORD_W +: WORD_W]),
      .pin_o   (pin_o[b*WORD_W +: WORD_W]),
      .oe_o    (pin_oe_o[b*WORD_W +: WORD_W]),
      .stat_o  (stat_all[b*WORD_W +: WORD_W])
    );
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_irq
    egpio_irq_gate #(.W(GRP_W)) u_gate (
      .stat_i (stat_all[g*GRP_W +: GRP_W]),
      .en_i   (glb_en_q[g]),
      .irq_o  (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = glb_hit ? WORD_W'(glb_en_q) : '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel[b]) rdata_o = rdata_o | bank_rd[b];
  end
endmodule

// File: rtl/edge_gpio_ctrl_chk.sv
module edge_gpio_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [31:0]             wdata_i,
  input logic [NUM_BANKS*32-1:0] pin_o,
  input logic [NUM_BANKS*32-1:0] pin_oe_o,
  input logic [NUM_BANKS*2-1:0]  irq_o,
  input logic [NUM_BANKS*2-1:0]  glb_en_q
);
  localparam int NG = NUM_BANKS * 2;

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~glb_en_q) == '0);

  assert_glb_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(8) && wdata_i[NG-1:0] == '0) |=> irq_o == '0);

  assert_set_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(8'h18)) |=> (pin_o[31:0] & $past(wdata_i)) == $past(wdata_i));

  assert_clr_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(8'h1C)) |=> (pin_o[31:0] & $past(wdata_i)) == 32'h0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dir
    assert_dir_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(16 + 40 * b)) |=> $stable(pin_oe_o[b*32 +: 32]));
  end
endmodule

bind edge_gpio_ctrl edge_gpio_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .glb_en_q (glb_en_q)
);

// File: tb/sim_edge_gpio_ctrl.sv
module sim_edge_gpio_ctrl;
  localparam int NB = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [7:0]    addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [NB*32-1:0] pin_i = '0;
  logic [NB*32-1:0] pin_o, pin_oe_o;
  logic [NB*2-1:0]  irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  kind;   // 0 rdata, 1 irq, 2 oe low bank, 3 pin_o low bank
    logic [31:0] exp;
  } item_t;
  item_t exp_q[$];
  string tag_q[$];

  always #5 clk_i = ~clk_i;

  edge_gpio_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) u0 (.*);

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic expect_item(input logic [1:0] k, input logic [7:0] a,
                             input logic [31:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a;
    exp_q.push_back('{kind: k, exp: e});
    tag_q.push_back(tag);
    @(posedge clk_i);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expect_item(2'd0, a, e, tag);
  endtask

  task automatic pin(input int idx, input logic v);
    @(negedge clk_i);
    pin_i[idx] = v;
    repeat (4) @(posedge clk_i);
  endtask

  // monitor: pops expectations and compares with what the design presents
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        item_t it;
        string tg;
        logic [31:0] act;
        it = exp_q.pop_front();
        tg = tag_q.pop_front();
        case (it.kind)
          2'd0: act = rdata_o;
          2'd1: act = 32'(irq_o);
          2'd2: act = pin_oe_o[31:0];
          default: act = pin_o[31:0];
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", tg, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(8'h10, 32'hFFFF_FFFF, "R1 dir0");
    rd(8'h38, 32'hFFFF_FFFF, "R1 dir1");
    rd(8'h14, 32'h0, "R1 dout");
    rd(8'h34, 32'h0, "R1 stat");
    rd(8'h08, 32'h0, "R1 glb");
    expect_item(2'd1, 8'h00, 32'h0, "R1 irq");
    expect_item(2'd2, 8'h00, 32'h0, "R1 oe");

    // R2 direction, R3 set/clear
    wr(8'h10, 32'hFFFF_0000);
    expect_item(2'd2, 8'h00, 32'h0000_FFFF, "R2 oe");
    wr(8'h18, 32'h0000_00F0);
    rd(8'h14, 32'h0000_00F0, "R3 set");
    expect_item(2'd3, 8'h00, 32'h0000_00F0, "R2 pin_o");
    rd(8'h18, 32'h0000_00F0, "R3 set port read");
    wr(8'h1C, 32'h0000_0030);
    rd(8'h1C, 32'h0000_00C0, "R3 clear");
    wr(8'h14, 32'h1234_5678);
    rd(8'h14, 32'h1234_5678, "R3 direct");

    // R11 bank isolation, unmapped read
    wr(8'h40, 32'h0000_0001);
    rd(8'h3C, 32'h0000_0001, "R11 bank1 dout");
    rd(8'h14, 32'h1234_5678, "R11 bank0 untouched");
    rd(8'h00, 32'h0, "R11 unmapped");

    // R4 synchronizer latency
    @(negedge clk_i);
    pin_i[5] = 1'b1;
    rd(8'h20, 32'h0, "R4 one edge");
    rd(8'h20, 32'h0000_0020, "R4 two edges");

    // R5 rising enable; R7 unenabled pin5 never flagged
    wr(8'h24, 32'h1);
    rd(8'h24, 32'h1, "R5 set rise");
    pin(0, 1'b1);
    rd(8'h34, 32'h1, "R5 R7 rise status");
    wr(8'h28, 32'h1);
    rd(8'h28, 32'h0, "R5 clear rise");

    // R8 write-one-to-clear
    wr(8'h24, 32'h2);
    pin(1, 1'b1);
    rd(8'h34, 32'h3, "R8 before");
    wr(8'h34, 32'h1);
    rd(8'h34, 32'h2, "R8 partial");
    wr(8'h34, 32'h2);
    rd(8'h34, 32'h0, "R8 all");

    // R6 falling
    wr(8'h28, 32'h3);
    wr(8'h2C, 32'h1);
    rd(8'h2C, 32'h1, "R6 set fall");
    pin(0, 1'b0);
    rd(8'h34, 32'h1, "R6 fall status");
    wr(8'h34, 32'h1);
    pin(0, 1'b1);
    rd(8'h34, 32'h0, "R6 rise ignored");
    wr(8'h30, 32'h1);
    rd(8'h30, 32'h0, "R6 clear fall");

    // R7 both edges
    wr(8'h24, 32'h4);
    wr(8'h1C, 32'h0);
    wr(8'h2C, 32'h4);
    pin(2, 1'b1);
    rd(8'h34, 32'h4, "R7 rise");
    wr(8'h34, 32'h4);
    pin(2, 1'b0);
    rd(8'h34, 32'h4, "R7 fall");

    // R10 grouped interrupts
    expect_item(2'd1, 8'h00, 32'h0, "R10 gated off");
    wr(8'h08, 32'h1);
    expect_item(2'd1, 8'h00, 32'h1, "R10 group0");
    wr(8'h08, 32'h2);
    expect_item(2'd1, 8'h00, 32'h0, "R10 group1 empty");
    wr(8'h24, 32'h0010_0000);
    pin(20, 1'b1);
    expect_item(2'd1, 8'h00, 32'h2, "R10 group1");
    wr(8'h4C, 32'h0001_0000);
    pin(48, 1'b1);
    wr(8'h08, 32'hF);
    expect_item(2'd1, 8'h00, 32'hB, "R10 all groups");
    rd(8'h08, 32'hF, "R10 glb read");
    rd(8'h5C, 32'h0001_0000, "R11 bank1 status");

    // R9 clear and edge in the same cycle
    @(negedge clk_i);
    pin_i[2] = 1'b1;
    @(negedge clk_i);
    wr(8'h34, 32'h4);
    rd(8'h34, 32'h0010_0004, "R9 edge wins");
    wr(8'h34, 32'h4);
    rd(8'h34, 32'h0010_0000, "R9 plain clear");

    wr(8'h08, 32'h0);
    expect_item(2'd1, 8'h00, 32'h0, "R10 disabled");

    repeat (3) @(posedge clk_i);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule